// File: doc/BRIEF.md
# Sensor Self-Test Sequencer

This block is the digital controller of a built-in self-test for a field or current sensor. It shares one open-drain fault line with the outside world. It reads the line's level through a synchronizer and pulls the line low itself. An external device starts the test by holding the line low. Once the line has stayed low long enough, the block moves the analog output stage through a fixed series of test levels and keeps the fault line in step with them. When the series is over, it returns to normal operation.

The block keeps time by counting a prescaled tick input. A 4-bit code sets the start delay. Two 2-bit codes set the request delay and the pulse-width delay. All three codes are captured when the start wait begins. Outside the test, the fault pull-down follows the digital over-field comparator and the output select stays at its normal value. During the two saturation phases, the block forces the output clamp enable off.

The states are:
- `ST_NORMAL`: mission mode.
- `ST_ARMING`: start wait.
- `ST_HOLD_LOW`: self-test-low.
- `ST_REQ_HIGH`: self-test-high.
- `ST_SAT_HI`: high saturation.
- `ST_QUIESCENT`: quiescent level.
- `ST_SAT_LO`: low saturation.

The transitions are:
- `ST_NORMAL` to `ST_ARMING` when the line reads low, the disable bit is 0 and no over-field is present.
- `ST_ARMING` to `ST_NORMAL` when the line reads high or the disable bit is set.
- `ST_ARMING` to `ST_HOLD_LOW` when the start count completes.
- `ST_HOLD_LOW` to `ST_REQ_HIGH` when the line reads high.
- `ST_REQ_HIGH` to `ST_SAT_HI` when the request count completes.
- `ST_SAT_HI` to `ST_QUIESCENT`, `ST_QUIESCENT` to `ST_SAT_LO`, and `ST_SAT_LO` to `ST_NORMAL`, each when the pulse-width count completes.

Top module: `selftest_seq`

## Requirements
- R1: While `st_disable_i` is 1, a low fault line never starts the test. Setting the bit during the start wait abandons the wait, and `level_sel_o` stays 000.
- R2: The test enters self-test-low (`level_sel_o` = 001) only after the line has read low without a break for the full start count. A shorter low pulse leaves the output at 000. With a tick every third clock, the bench measures start count + 1 ticks from the pull-low to 001: one tick passes during the two synchronizer stages and the entry into the wait.
- R3: An over-field indication during the start wait clears the start count, so that the full count must pass again after it.
- R4: The start count in ticks is START_STEP × (min(code, 11) + 1). Codes 11 to 15 all give the same delay.
- R5: Self-test-low (001) lasts for as long as the line reads low.
- R6: When the line is released, `level_sel_o` is 010 for FR_BASE << request-code ticks.
- R7: The three phases that follow each last PW_BASE << width-code ticks. Their order is: 011 with `line_pull_o` = 1, then 100 with `line_pull_o` = 0, then 101 with `line_pull_o` = 1. After them the output returns to 000.
- R8: `clamp_en_o` is 0 in both saturation phases and equals `clamp_en_i` in every other phase.
- R9: In mission mode, `level_sel_o` is 000 and `line_pull_o` equals `overfield_i`.
- R10: The three codes are captured when the start wait begins. Changing them later does not change any phase duration of that run.
- R11: A synchronous active-low reset gives `level_sel_o` = 000 and `line_pull_o` = 0 while `overfield_i` is 0.
- R12: From the release of the line until the return to mission mode, the line level has no effect on the order or the durations of the phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Prescaled time tick, one clock wide |
| st_disable_i | input | 1 | Self-test disable configuration bit |
| start_code_i | input | 4 | Start-delay code |
| req_code_i | input | 2 | Request-delay code |
| pw_code_i | input | 2 | Pulse-width code |
| line_lvl_i | input | 1 | Sampled fault-line level, 1 = high |
| overfield_i | input | 1 | Over-field comparator result |
| clamp_en_i | input | 1 | Programmed output-clamp enable |
| level_sel_o | output | 3 | Encoded output-level select |
| line_pull_o | output | 1 | Fault-line pull-down enable |
| clamp_en_o | output | 1 | Effective clamp enable |

## Verification
The bench builds the block with START_STEP = 2, FR_BASE = 2, PW_BASE = 2 and an 8-bit count. It drives a tick every third clock. With these values, every start code, including the aliased codes 11 to 15, completes within a few hundred clocks, so the aliasing, the exact start latency and the over-field restart can each be measured to the tick. The small request and pulse-width bases keep complete runs short. Several runs can then cover mid-run code changes, an external pull-low during the post-release phases, and both clamp settings.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL    = 3'd0,
        ST_ARMING    = 3'd1,
        ST_HOLD_LOW  = 3'd2,
        ST_REQ_HIGH  = 3'd3,
        ST_SAT_HI    = 3'd4,
        ST_QUIESCENT = 3'd5,
        ST_SAT_LO    = 3'd6
    } seq_state_e;

    localparam logic [2:0] LVL_NORMAL  = 3'b000;
    localparam logic [2:0] LVL_ST_LOW  = 3'b001;
    localparam logic [2:0] LVL_ST_HIGH = 3'b010;
    localparam logic [2:0] LVL_SAT_HI  = 3'b011;
    localparam logic [2:0] LVL_QUIES   = 3'b100;
    localparam logic [2:0] LVL_SAT_LO  = 3'b101;

endpackage

// File: rtl/st_sync2.sv
module st_sync2 #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    chain_q[g] <= d_i;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/st_delay_lut.sv
module st_delay_lut #(
    parameter int CNT_W        = 10,
    parameter int START_CODE_W = 4,
    parameter int PHASE_CODE_W = 2,
    parameter int START_LEVELS = 12,
    parameter int START_STEP   = 16,
    parameter int FR_BASE      = 8,
    parameter int PW_BASE      = 8
) (
    input  logic [START_CODE_W-1:0] start_code_i,
    input  logic [PHASE_CODE_W-1:0] req_code_i,
    input  logic [PHASE_CODE_W-1:0] pw_code_i,
    output logic [CNT_W-1:0]        start_tgt_o,
    output logic [CNT_W-1:0]        req_tgt_o,
    output logic [CNT_W-1:0]        pw_tgt_o
);
    localparam int TOP_IDX = START_LEVELS - 1;

    logic [CNT_W-1:0] start_idx;

    always_comb begin
        if (int'(start_code_i) >= TOP_IDX) begin
            start_idx = CNT_W'(TOP_IDX);
        end else begin
            start_idx = CNT_W'(start_code_i);
        end
        start_tgt_o = CNT_W'(START_STEP) * (start_idx + CNT_W'(1));
        req_tgt_o   = CNT_W'(FR_BASE) << req_code_i;
        pw_tgt_o    = CNT_W'(PW_BASE) << pw_code_i;
    end
endmodule

// File: rtl/st_phase_timer.sv
module st_phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    assign done_o = tick_i && (cnt_q == target_i - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= done_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

    AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && $past(!clr_i) && $stable(target_i)) |-> (cnt_q < target_i)); // R7
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
    import selftest_pkg::*;
#(
    parameter int CNT_W        = 10,
    parameter int START_CODE_W = 4,
    parameter int PHASE_CODE_W = 2,
    parameter int START_LEVELS = 12,
    parameter int START_STEP   = 16,
    parameter int FR_BASE      = 8,
    parameter int PW_BASE      = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       st_disable_i,
    input  logic [3:0] start_code_i,
    input  logic [1:0] req_code_i,
    input  logic [1:0] pw_code_i,
    input  logic       line_lvl_i,
    input  logic       overfield_i,
    input  logic       clamp_en_i,
    output logic [2:0] level_sel_o,
    output logic       line_pull_o,
    output logic       clamp_en_o
);
    seq_state_e state_q, state_d;

    logic                    line_hi;
    logic                    phase_done;
    logic                    timer_clr;
    logic                    capture;
    logic [CNT_W-1:0]        timer_tgt;
    logic [CNT_W-1:0]        start_tgt, req_tgt, pw_tgt;
    logic [START_CODE_W-1:0] start_code_q;
    logic [PHASE_CODE_W-1:0] req_code_q, pw_code_q;

    st_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_lvl_i),
        .q_o   (line_hi)
    );

    st_delay_lut #(
        .CNT_W        (CNT_W),
        .START_CODE_W (START_CODE_W),
        .PHASE_CODE_W (PHASE_CODE_W),
        .START_LEVELS (START_LEVELS),
        .START_STEP   (START_STEP),
        .FR_BASE      (FR_BASE),
        .PW_BASE      (PW_BASE)
    ) u_lut (
        .start_code_i (start_code_q),
        .req_code_i   (req_code_q),
        .pw_code_i    (pw_code_q),
        .start_tgt_o  (start_tgt),
        .req_tgt_o    (req_tgt),
        .pw_tgt_o     (pw_tgt)
    );

    st_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (timer_clr),
        .tick_i   (tick_i),
        .target_i (timer_tgt),
        .done_o   (phase_done)
    );

    assign capture = (state_q == ST_NORMAL) && (state_d == ST_ARMING);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_code_q <= '0;
            req_code_q   <= '0;
            pw_code_q    <= '0;
        end else if (capture) begin
            start_code_q <= START_CODE_W'(start_code_i);
            req_code_q   <= PHASE_CODE_W'(req_code_i);
            pw_code_q    <= PHASE_CODE_W'(pw_code_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (!st_disable_i && !line_hi && !overfield_i) state_d = ST_ARMING;
            end
            ST_ARMING: begin
                if (st_disable_i || line_hi)         state_d = ST_NORMAL;
                else if (!overfield_i && phase_done) state_d = ST_HOLD_LOW;
            end
            ST_HOLD_LOW: begin
                if (line_hi) state_d = ST_REQ_HIGH;
            end
            ST_REQ_HIGH: begin
                if (phase_done) state_d = ST_SAT_HI;
            end
            ST_SAT_HI: begin
                if (phase_done) state_d = ST_QUIESCENT;
            end
            ST_QUIESCENT: begin
                if (phase_done) state_d = ST_SAT_LO;
            end
            ST_SAT_LO: begin
                if (phase_done) state_d = ST_NORMAL;
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    always_comb begin
        timer_clr = (state_q != state_d) || (state_q == ST_NORMAL) || (state_q == ST_HOLD_LOW)
                  || ((state_q == ST_ARMING) && overfield_i);
        unique case (state_q)
            ST_ARMING:   timer_tgt = start_tgt;
            ST_REQ_HIGH: timer_tgt = req_tgt;
            default:     timer_tgt = pw_tgt;
        endcase
    end

    always_comb begin
        level_sel_o = LVL_NORMAL;
        line_pull_o = 1'b0;
        clamp_en_o  = clamp_en_i;
        unique case (state_q)
            ST_NORMAL, ST_ARMING: begin
                line_pull_o = overfield_i;
            end
            ST_HOLD_LOW:  level_sel_o = LVL_ST_LOW;
            ST_REQ_HIGH:  level_sel_o = LVL_ST_HIGH;
            ST_SAT_HI: begin
                level_sel_o = LVL_SAT_HI;
                line_pull_o = 1'b1;
                clamp_en_o  = 1'b0;
            end
            ST_QUIESCENT: level_sel_o = LVL_QUIES;
            ST_SAT_LO: begin
                level_sel_o = LVL_SAT_LO;
                line_pull_o = 1'b1;
                clamp_en_o  = 1'b0;
            end
            default: level_sel_o = LVL_NORMAL;
        endcase
    end

    AST_DISABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && st_disable_i) |=> (level_sel_o == LVL_NORMAL)); // R1
    AST_OVF_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMING && overfield_i) |=> (level_sel_o != LVL_ST_LOW)); // R3
    AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (level_sel_o == LVL_ST_LOW && !line_hi) |=> (level_sel_o == LVL_ST_LOW)); // R5
    AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (level_sel_o == LVL_ST_LOW && line_hi) |=> (level_sel_o == LVL_ST_HIGH)); // R6
    AST_SATHI_TO_QUIES: assert property (@(posedge clk) disable iff (!rst_n)
        (level_sel_o == LVL_SAT_HI && phase_done) |=> (level_sel_o == LVL_QUIES && !line_pull_o)); // R7
    AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_NORMAL) |=> ($stable(start_code_q) && $stable(req_code_q) && $stable(pw_code_q))); // R10
endmodule

// File: tb/selftest_seq_tb.sv
module selftest_seq_tb;
    localparam int CLK_PERIOD   = 10;
    localparam int TICK_DIV     = 3;
    localparam int CNT_W        = 8;
    localparam int START_LEVELS = 12;
    localparam int START_STEP   = 2;
    localparam int FR_BASE      = 2;
    localparam int PW_BASE      = 2;

    typedef struct {
        int    lvl;
        int    pull;
        int    clamp;
        int    ticks;
        string tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i;
    logic       st_disable_i = 1'b0;
    logic [3:0] start_code_i = '0;
    logic [1:0] req_code_i = '0;
    logic [1:0] pw_code_i = '0;
    logic       line_lvl_i;
    logic       overfield_i = 1'b0;
    logic       clamp_en_i = 1'b0;
    logic [2:0] level_sel_o;
    logic       line_pull_o;
    logic       clamp_en_o;
    logic       ext_low = 1'b0;
    int         div_cnt = 0;

    int n_tests = 0;
    int n_fail  = 0;
    exp_item_t exp_q[$];

    int cur_lvl = 0;
    int ph_ticks = 0;
    int ph_pull = 0;
    int ph_clamp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) div_cnt <= (div_cnt == TICK_DIV-1) ? 0 : div_cnt + 1;
    assign tick_i     = (div_cnt == 0);
    assign line_lvl_i = ~(ext_low | line_pull_o);

    selftest_seq #(
        .CNT_W        (CNT_W),
        .START_LEVELS (START_LEVELS),
        .START_STEP   (START_STEP),
        .FR_BASE      (FR_BASE),
        .PW_BASE      (PW_BASE)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .st_disable_i (st_disable_i),
        .start_code_i (start_code_i),
        .req_code_i   (req_code_i),
        .pw_code_i    (pw_code_i),
        .line_lvl_i   (line_lvl_i),
        .overfield_i  (overfield_i),
        .clamp_en_i   (clamp_en_i),
        .level_sel_o  (level_sel_o),
        .line_pull_o  (line_pull_o),
        .clamp_en_o   (clamp_en_o)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic int start_ticks(input int code);
        return START_STEP * (((code > START_LEVELS-1) ? START_LEVELS-1 : code) + 1);
    endfunction

    task automatic push_item(input int lvl, input int pull, input int clamp, input int ticks, input string tag);
        exp_item_t it;
        it.lvl = lvl; it.pull = pull; it.clamp = clamp; it.ticks = ticks; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Driver side of the scoreboard: expected phases of one run
    task automatic push_run(input int rcode, input int pcode, input int clamp);
        push_item(1, 0, clamp, -1, "R5");
        push_item(2, 0, clamp, FR_BASE << rcode, "R6");
        push_item(3, 1, 0, PW_BASE << pcode, "R7");
        push_item(4, 0, clamp, PW_BASE << pcode, "R7");
        push_item(5, 1, 0, PW_BASE << pcode, "R7");
    endtask

    // Monitor side: closes each phase when the select changes
    always @(negedge clk) begin
        if (rst_n) begin
            if (int'(level_sel_o) != cur_lvl) begin
                if (cur_lvl != 0) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R2", "unexpected phase level", cur_lvl, 0);
                    end else begin
                        exp_item_t e;
                        e = exp_q.pop_front();
                        chk(cur_lvl == e.lvl, e.tag, "phase level", cur_lvl, e.lvl);
                        chk(ph_pull == e.pull, e.tag, "phase pull", ph_pull, e.pull);
                        chk(ph_clamp == e.clamp, "R8", "phase clamp", ph_clamp, e.clamp);
                        if (e.ticks >= 0)
                            chk(ph_ticks == e.ticks, e.tag, "phase ticks", ph_ticks, e.ticks);
                    end
                end
                cur_lvl  = int'(level_sel_o);
                ph_ticks = 0;
                ph_pull  = int'(line_pull_o);
                ph_clamp = int'(clamp_en_o);
            end
            if (level_sel_o != 3'b000 && tick_i) ph_ticks++;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_level(input int lvl, input int max_cyc, input string tag);
        int k;
        k = 0;
        @(negedge clk);
        while (int'(level_sel_o) != lvl && k < max_cyc) begin
            @(negedge clk);
            k++;
        end
        chk(int'(level_sel_o) == lvl, tag, "reached level", int'(level_sel_o), lvl);
        @(posedge clk); #1;
    endtask

    // Full run: measures ticks from pull-low to self-test-low
    task automatic run_full(input int scode, input int rcode, input int pcode, input int clamp,
                            input bit poke_line, output int measured);
        int k;
        start_code_i = 4'(scode); req_code_i = 2'(rcode); pw_code_i = 2'(pcode);
        clamp_en_i = clamp[0];
        push_run(rcode, pcode, clamp);
        @(posedge clk); #1;
        ext_low = 1'b1;
        measured = 0; k = 0;
        @(negedge clk);
        while (level_sel_o != 3'b001 && k < 2000) begin
            if (tick_i) measured++;
            @(negedge clk);
            k++;
        end
        @(posedge clk); #1;
        start_code_i = ~start_code_i; req_code_i = ~req_code_i; pw_code_i = ~pw_code_i; // R10
        cyc(7);
        ext_low = 1'b0;
        if (poke_line) begin
            wait_level(4, 500, "R12");
            ext_low = 1'b1;
            wait_level(5, 500, "R12");
            ext_low = 1'b0;
        end
        wait_level(0, 1000, "R7");
        cyc(4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "R7", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int m;
        int t;
        clamp_en_i = 1'b1;
        cyc(5);
        chk(level_sel_o == 3'b000, "R11", "reset level", int'(level_sel_o), 0);
        chk(line_pull_o == 1'b0, "R11", "reset pull", int'(line_pull_o), 0);
        rst_n = 1'b1;
        cyc(3);
        chk(clamp_en_o == 1'b1, "R8", "normal clamp", int'(clamp_en_o), 1);

        // R9: pull follows over-field in mission mode
        overfield_i = 1'b1; cyc(1);
        chk(line_pull_o == 1'b1, "R9", "pull with overfield", int'(line_pull_o), 1);
        chk(level_sel_o == 3'b000, "R9", "level with overfield", int'(level_sel_o), 0);
        overfield_i = 1'b0; cyc(1);
        chk(line_pull_o == 1'b0, "R9", "pull without overfield", int'(line_pull_o), 0);
        cyc(10);

        // R1: disabled, long hold has no effect
        st_disable_i = 1'b1; start_code_i = 4'd0;
        ext_low = 1'b1; cyc(start_ticks(15) * TICK_DIV * 2);
        chk(level_sel_o == 3'b000, "R1", "disabled level", int'(level_sel_o), 0);
        ext_low = 1'b0; st_disable_i = 1'b0; cyc(10);

        // R2: short pulse ignored
        start_code_i = 4'd3; t = start_ticks(3);
        ext_low = 1'b1; cyc((t - 1) * TICK_DIV);
        ext_low = 1'b0; cyc(12);
        chk(level_sel_o == 3'b000, "R2", "short pulse level", int'(level_sel_o), 0);

        // R2 R10: exact start latency, codes flipped mid-run
        run_full(3, 1, 2, 1, 1'b0, m);
        chk(m == start_ticks(3) + 1, "R2", "start latency ticks", m, start_ticks(3) + 1);

        // R4: code aliasing
        run_full(11, 0, 0, 0, 1'b0, m);
        chk(m == start_ticks(11) + 1, "R4", "code 11 ticks", m, start_ticks(11) + 1);
        run_full(14, 3, 1, 1, 1'b0, m);
        chk(m == start_ticks(11) + 1, "R4", "code 14 ticks", m, start_ticks(11) + 1);
        run_full(0, 2, 3, 0, 1'b0, m);
        chk(m == start_ticks(0) + 1, "R4", "code 0 ticks", m, start_ticks(0) + 1);

        // R12: external pull-low during the quiescent phase has no effect
        run_full(1, 1, 1, 1, 1'b1, m);

        // R3: over-field restarts the start wait
        start_code_i = 4'd5; req_code_i = 2'd0; pw_code_i = 2'd0; clamp_en_i = 1'b1;
        t = start_ticks(5);
        push_run(0, 0, 1);
        ext_low = 1'b1; cyc((t - 1) * TICK_DIV);
        overfield_i = 1'b1; cyc(1); overfield_i = 1'b0;
        cyc((t - 2) * TICK_DIV);
        chk(level_sel_o == 3'b000, "R3", "level after overfield restart", int'(level_sel_o), 0);
        wait_level(1, 200, "R3");
        ext_low = 1'b0;
        wait_level(0, 500, "R7");
        cyc(5);

        // R1: disable during the start wait abandons it
        start_code_i = 4'd6;
        ext_low = 1'b1; cyc(6);
        st_disable_i = 1'b1; cyc(start_ticks(6) * TICK_DIV + 6);
        chk(level_sel_o == 3'b000, "R1", "disable mid-wait level", int'(level_sel_o), 0);
        ext_low = 1'b0; st_disable_i = 1'b0; cyc(10);

        chk(exp_q.size() == 0, "R7", "pending expected phases", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule